// File: doc/BRIEF.md
# Repeated String Operation Sequencer

This block executes one string instruction of a classic byte-addressed processor, one element after another, until it is finished. It supports seven operations: move, compare, store, load, scan, port input and port output. Element sizes are 1, 2 or 4 bytes. A repeat mode selects single execution, repetition while the compared pair is equal, or repetition while it differs. The surrounding core latches the source pointer, destination pointer, count, accumulator and port number on a start pulse. The block then runs its own memory and port transactions. When it ends, it pulses done, and the updated registers and compare flags are ready to be written back.

Memory is reached through a request/acknowledge port with one access in flight. A memory fault reaches the block as an abort in place of the acknowledge. A privilege decision for the port number and element size comes back from outside on a combinational permit input. Address translation, segments and any bulk transfer path belong to other blocks.

Top module: `strseq_core`

## Requirements
- R1: Move, compare, load and port output use and advance the source pointer. Move, compare, store, scan and port input use and advance the destination pointer. A pointer an operation does not use keeps its value. Operation codes: 0 move, 1 compare, 2 store, 3 load, 4 scan, 5 port input, 6 port output.
- R2: Size codes are 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes. After each completed element, each used pointer advances by the element size. It advances up when the direction input is 0 and down when it is 1.
- R3: With wide_addr = 0, memory addresses carry only the low 16 pointer bits, with zero upper bits. Pointer and count arithmetic wraps inside the low 16 bits, and bits 31:16 of src_ptr, dst_ptr and count keep their start values.
- R4: Repeat codes are 0 = single, 1 = repeat while equal, 2 = repeat while not equal. With a repeat code and a count that is zero in the active address width, done follows with no memory or port access and no register or flag change.
- R5: Under repeat, count drops by one per completed element, and the instruction ends when it reaches zero. Move, store, load and port operations ignore the equality outcome. With repeat code 0, exactly one element runs and count is unchanged.
- R6: A repeated compare or scan also ends after the first element whose pair is unequal (code 1) or equal (code 2).
- R7: Compare and scan set flag_c, flag_z, flag_s and flag_o to the borrow, zero, sign and signed-overflow results of source minus destination at the element width. Scan takes the accumulator's low bits as its source. Only the final element's pair sets the flags, and other operations leave them unchanged.
- R8: Port operations present port_init and the element size on io_port and io_size. If io_permit is low, the instruction ends with no access and no register change.
- R9: Port input first issues a writability probe of the destination (mem_probe high). Only after that probe is acknowledged does it read the port and write the value to memory. An aborted probe consumes no port data.
- R10: Load replaces only the low 8, 16 or 32 bits of the accumulator. Store writes the accumulator's low bits to the destination.
- R11: A mem_abort ends the instruction with fault high during the done cycle. All registers and flags then hold the values after the last fully completed element.
- R12: The block never requests memory and a port at the same time. A memory request holds its address and type until it is acknowledged or aborted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Latch operands and begin one instruction |
| op_sel | input | 3 | Operation code |
| elem_size | input | 2 | Element size code |
| rep_mode | input | 2 | Repeat code |
| wide_addr | input | 1 | 1 = 32-bit pointers, 0 = 16-bit pointers |
| dir_down | input | 1 | 1 = pointers step downward |
| src_init | input | AW | Starting source pointer |
| dst_init | input | AW | Starting destination pointer |
| cnt_init | input | AW | Starting count |
| acc_init | input | DW | Starting accumulator |
| port_init | input | PW | Port number |
| done | output | 1 | One-cycle end-of-instruction pulse |
| fault | output | 1 | High with done when a memory abort ended the instruction |
| src_ptr | output | AW | Current source pointer |
| dst_ptr | output | AW | Current destination pointer |
| count | output | AW | Current count |
| acc | output | DW | Current accumulator |
| flag_c | output | 1 | Borrow flag |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_o | output | 1 | Signed overflow flag |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write or writability probe |
| mem_probe | output | 1 | Writability probe, no data transferred |
| mem_addr | output | AW | Access byte address |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | DW | Write data, low bits valid |
| mem_ack | input | 1 | Access completed |
| mem_abort | input | 1 | Access faulted |
| mem_rdata | input | DW | Read data, low bits valid |
| io_port | output | PW | Port number for permission and access |
| io_size | output | 2 | Port access size code |
| io_permit | input | 1 | Port access allowed |
| io_req | output | 1 | Port access request |
| io_we | output | 1 | 1 = port write |
| io_wdata | output | DW | Port write data |
| io_ack | input | 1 | Port access completed |
| io_rdata | input | DW | Port read data |

## Verification
The hardest situation to reach is a fault partway through a repeated instruction. The abort must land on a chosen element, and for port input it must hit the writability probe before any port data has been consumed. The stimulus places a fault address a random number of elements ahead along the source or destination walk. It does so under both directions and both address widths, and directed runs pin the probe fault and a 16-bit descending wrap. Memory is filled from a two-value byte alphabet in half of the runs, so that repeated compares and scans often stop on an equality change instead of on the count.

// File: rtl/strseq_pkg.sv
package strseq_pkg;

   typedef enum logic [2:0] {
      OP_MOVE  = 3'd0,
      OP_CMP   = 3'd1,
      OP_STORE = 3'd2,
      OP_LOAD  = 3'd3,
      OP_SCAN  = 3'd4,
      OP_PIN   = 3'd5,
      OP_POUT  = 3'd6
   } op_e;

   typedef enum logic [1:0] {
      REP_NONE = 2'd0,
      REP_EQ   = 2'd1,
      REP_NE   = 2'd2
   } rep_e;

   typedef enum logic [3:0] {
      S_IDLE, S_CHK, S_RDS, S_RDD, S_PRB, S_IOR, S_IOW, S_WRD, S_STEP, S_DONE
   } state_e;

   function automatic logic [31:0] lane_mask(input logic [1:0] sz);
      case (sz)
         2'd0:    return 32'h0000_00FF;
         2'd1:    return 32'h0000_FFFF;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

   function automatic logic uses_src(input op_e op);
      return op inside {OP_MOVE, OP_CMP, OP_LOAD, OP_POUT};
   endfunction

   function automatic logic uses_dst(input op_e op);
      return op inside {OP_MOVE, OP_CMP, OP_STORE, OP_SCAN, OP_PIN};
   endfunction

   function automatic logic is_cmp(input op_e op);
      return op inside {OP_CMP, OP_SCAN};
   endfunction

   function automatic logic is_port(input op_e op);
      return op inside {OP_PIN, OP_POUT};
   endfunction

endpackage

// File: rtl/strseq_ptr_step.sv
module strseq_ptr_step #(
   parameter int AW = 32,
   parameter int NW = 16
) (
   input  logic [AW-1:0] cur,
   input  logic [AW-1:0] delta,
   input  logic          wide,
   output logic [AW-1:0] nxt
);
   if (NW < 1 || NW >= AW) begin : g_bad_width
      $error("strseq_ptr_step: NW must lie between 1 and AW-1");
   end

   logic [NW-1:0] low_sum;
   assign low_sum = cur[NW-1:0] + delta[NW-1:0];
   assign nxt     = wide ? (cur + delta) : {cur[AW-1:NW], low_sum};
endmodule

// File: rtl/strseq_flags.sv
module strseq_flags #(
   parameter int DW = 32
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic [1:0]    sz,
   output logic          cf,
   output logic          zf,
   output logic          sf,
   output logic          of,
   output logic          eq
);
   if (DW != 32) begin : g_bad_width
      $error("strseq_flags: element lanes need DW of 32");
   end

   logic [DW-1:0] diff, msk;
   logic [4:0]    mi;

   always_comb begin
      msk  = strseq_pkg::lane_mask(sz);
      diff = a - b;
      case (sz)
         2'd0:    mi = 5'd7;
         2'd1:    mi = 5'd15;
         default: mi = 5'd31;
      endcase
      cf = (a & msk) < (b & msk);
      zf = ((diff & msk) == '0);
      sf = diff[mi];
      of = (a[mi] ^ b[mi]) & (diff[mi] ^ a[mi]);
      eq = ((a & msk) == (b & msk));
   end
endmodule

// File: rtl/strseq_core.sv
module strseq_core
   import strseq_pkg::*;
#(
   parameter int AW = 32,
   parameter int NW = 16,
   parameter int DW = 32,
   parameter int PW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [2:0]    op_sel,
   input  logic [1:0]    elem_size,
   input  logic [1:0]    rep_mode,
   input  logic          wide_addr,
   input  logic          dir_down,
   input  logic [AW-1:0] src_init,
   input  logic [AW-1:0] dst_init,
   input  logic [AW-1:0] cnt_init,
   input  logic [DW-1:0] acc_init,
   input  logic [PW-1:0] port_init,
   output logic          done,
   output logic          fault,
   output logic [AW-1:0] src_ptr,
   output logic [AW-1:0] dst_ptr,
   output logic [AW-1:0] count,
   output logic [DW-1:0] acc,
   output logic          flag_c,
   output logic          flag_z,
   output logic          flag_s,
   output logic          flag_o,
   output logic          mem_req,
   output logic          mem_we,
   output logic          mem_probe,
   output logic [AW-1:0] mem_addr,
   output logic [1:0]    mem_size,
   output logic [DW-1:0] mem_wdata,
   input  logic          mem_ack,
   input  logic          mem_abort,
   input  logic [DW-1:0] mem_rdata,
   output logic [PW-1:0] io_port,
   output logic [1:0]    io_size,
   input  logic          io_permit,
   output logic          io_req,
   output logic          io_we,
   output logic [DW-1:0] io_wdata,
   input  logic          io_ack,
   input  logic [DW-1:0] io_rdata
);
   localparam int NREG = 3;       // 0 source, 1 destination, 2 count
   localparam int HW   = AW - NW;

   if (DW != 32) begin : g_bad_dw
      $error("strseq_core: DW must be 32");
   end
   if (AW < DW || NW >= AW) begin : g_bad_aw
      $error("strseq_core: AW must be at least DW and exceed NW");
   end

   state_e        st;
   op_e           op_q;
   rep_e          rep_q;
   logic [1:0]    sz_q;
   logic          wide_q, dir_q, fault_q, probe_ok_q;
   logic [AW-1:0] regs [NREG];
   logic [AW-1:0] nxt  [NREG];
   logic [AW-1:0] dlt  [NREG];
   logic [DW-1:0] acc_q, sval_q, dval_q, lm;
   logic [PW-1:0] port_q;
   logic [3:0]    flags_q;
   logic          f_c, f_z, f_s, f_o, f_eq;
   logic [AW-1:0] nb, inc;
   logic          cnt_zero, cnt_last, stop_now;
   state_e        first_st;

   assign lm  = lane_mask(sz_q);
   assign nb  = AW'(1) << sz_q;
   assign inc = dir_q ? (~nb + AW'(1)) : nb;

   for (genvar g = 0; g < NREG; g++) begin : g_step
      if (g == 2) begin : g_cnt
         assign dlt[g] = '1;
      end else begin : g_ptr
         assign dlt[g] = inc;
      end
      strseq_ptr_step #(.AW(AW), .NW(NW)) u_step (
         .cur(regs[g]), .delta(dlt[g]), .wide(wide_q), .nxt(nxt[g])
      );
   end

   strseq_flags #(.DW(DW)) u_flags (
      .a(sval_q), .b(dval_q), .sz(sz_q),
      .cf(f_c), .zf(f_z), .sf(f_s), .of(f_o), .eq(f_eq)
   );

   function automatic logic [AW-1:0] eff(input logic [AW-1:0] p, input logic w);
      return w ? p : {{HW{1'b0}}, p[NW-1:0]};
   endfunction

   always_comb begin
      case (op_q)
         OP_MOVE, OP_CMP, OP_LOAD, OP_POUT: first_st = S_RDS;
         OP_STORE:                          first_st = S_WRD;
         OP_SCAN:                           first_st = S_RDD;
         OP_PIN:                            first_st = S_PRB;
         default:                           first_st = S_DONE;
      endcase
      cnt_zero = wide_q ? (regs[2] == '0) : (regs[2][NW-1:0] == '0);
      cnt_last = wide_q ? (nxt[2] == '0)  : (nxt[2][NW-1:0] == '0);
      stop_now = (rep_q == REP_NONE) || cnt_last ||
                 (is_cmp(op_q) && (((rep_q == REP_EQ) && !f_eq) ||
                                   ((rep_q == REP_NE) &&  f_eq)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= S_IDLE;
         op_q       <= OP_MOVE;
         rep_q      <= REP_NONE;
         sz_q       <= '0;
         wide_q     <= 1'b0;
         dir_q      <= 1'b0;
         fault_q    <= 1'b0;
         probe_ok_q <= 1'b0;
         for (int i = 0; i < NREG; i++) regs[i] <= '0;
         acc_q      <= '0;
         sval_q     <= '0;
         dval_q     <= '0;
         port_q     <= '0;
         flags_q    <= '0;
      end else begin
         case (st)
            S_IDLE: if (start) begin
               op_q       <= op_e'(op_sel);
               rep_q      <= rep_e'(rep_mode);
               sz_q       <= elem_size;
               wide_q     <= wide_addr;
               dir_q      <= dir_down;
               regs[0]    <= src_init;
               regs[1]    <= dst_init;
               regs[2]    <= cnt_init;
               acc_q      <= acc_init;
               port_q     <= port_init;
               fault_q    <= 1'b0;
               probe_ok_q <= 1'b0;
               st         <= S_CHK;
            end
            S_CHK: begin
               if (is_port(op_q) && !io_permit)          st <= S_DONE;
               else if ((rep_q != REP_NONE) && cnt_zero) st <= S_DONE;
               else                                      st <= first_st;
            end
            S_RDS: begin
               if (mem_abort) begin
                  fault_q <= 1'b1;
                  st      <= S_DONE;
               end else if (mem_ack) begin
                  sval_q <= mem_rdata & lm;
                  case (op_q)
                     OP_CMP:  st <= S_RDD;
                     OP_POUT: st <= S_IOW;
                     OP_MOVE: st <= S_WRD;
                     default: st <= S_STEP;
                  endcase
               end
            end
            S_RDD: begin
               if (mem_abort) begin
                  fault_q <= 1'b1;
                  st      <= S_DONE;
               end else if (mem_ack) begin
                  dval_q <= mem_rdata & lm;
                  if (op_q == OP_SCAN) sval_q <= acc_q & lm;
                  st <= S_STEP;
               end
            end
            S_PRB: begin
               if (mem_abort) begin
                  fault_q <= 1'b1;
                  st      <= S_DONE;
               end else if (mem_ack) begin
                  probe_ok_q <= 1'b1;
                  st         <= S_IOR;
               end
            end
            S_IOR: if (io_ack) begin
               sval_q     <= io_rdata & lm;
               probe_ok_q <= 1'b0;
               st         <= S_WRD;
            end
            S_IOW: if (io_ack) st <= S_STEP;
            S_WRD: begin
               if (mem_abort) begin
                  fault_q <= 1'b1;
                  st      <= S_DONE;
               end else if (mem_ack) begin
                  st <= S_STEP;
               end
            end
            S_STEP: begin
               if (uses_src(op_q))     regs[0] <= nxt[0];
               if (uses_dst(op_q))     regs[1] <= nxt[1];
               if (rep_q != REP_NONE)  regs[2] <= nxt[2];
               if (op_q == OP_LOAD)    acc_q   <= (acc_q & ~lm) | sval_q;
               if (is_cmp(op_q))       flags_q <= {f_c, f_z, f_s, f_o};
               st <= stop_now ? S_DONE : first_st;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign done      = (st == S_DONE);
   assign fault     = done && fault_q;
   assign src_ptr   = regs[0];
   assign dst_ptr   = regs[1];
   assign count     = regs[2];
   assign acc       = acc_q;
   assign {flag_c, flag_z, flag_s, flag_o} = flags_q;

   assign mem_req   = st inside {S_RDS, S_RDD, S_PRB, S_WRD};
   assign mem_we    = st inside {S_PRB, S_WRD};
   assign mem_probe = (st == S_PRB);
   assign mem_addr  = eff((st == S_RDS) ? regs[0] : regs[1], wide_q);
   assign mem_size  = sz_q;
   assign mem_wdata = (op_q == OP_STORE) ? (acc_q & lm) : sval_q;
   assign io_port   = port_q;
   assign io_size   = sz_q;
   assign io_req    = st inside {S_IOR, S_IOW};
   assign io_we     = (st == S_IOW);
   assign io_wdata  = sval_q;

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack && !mem_abort) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_probe))); // R12
   AST_ONE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_req && io_req)); // R12
   AST_PROBE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (io_req && !io_we) |-> probe_ok_q); // R9
   AST_HIGH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_STEP && !wide_q) |=>
      (src_ptr[AW-1:NW] == $past(src_ptr[AW-1:NW]) &&
       dst_ptr[AW-1:NW] == $past(dst_ptr[AW-1:NW]) &&
       count[AW-1:NW]   == $past(count[AW-1:NW]))); // R3
   AST_ZERO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_CHK && rep_q != REP_NONE && cnt_zero) |=>
      (done && !mem_req && !io_req && $stable(count))); // R4
endmodule

// File: tb/sim_strseq_core.sv
module sim_strseq_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  op_sel = '0;
   logic [1:0]  elem_size = '0, rep_mode = '0;
   logic        wide_addr = 1'b0, dir_down = 1'b0;
   logic [31:0] src_init = '0, dst_init = '0, cnt_init = '0, acc_init = '0;
   logic [15:0] port_init = '0;
   logic        done, fault, flag_c, flag_z, flag_s, flag_o;
   logic [31:0] src_ptr, dst_ptr, count, acc;
   logic        mem_req, mem_we, mem_probe;
   logic [31:0] mem_addr, mem_wdata;
   logic [1:0]  mem_size, io_size;
   logic        mem_ack = 1'b0, mem_abort = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic [15:0] io_port;
   logic        io_permit, io_req, io_we;
   logic [31:0] io_wdata;
   logic        io_ack = 1'b0;
   logic [31:0] io_rdata = '0;

   always #4 clk = ~clk;   // 125 MHz

   strseq_core u0 (.*);

   int checks = 0, failures = 0, cycles = 0;
   logic [7:0]  mem  [4096];
   logic [7:0]  rmem [4096];
   logic        flt_en = 1'b0;
   logic [31:0] flt_addr = '0;
   int          io_rd_cnt = 0, acc_cnt = 0, viol = 0;
   logic [31:0] io_hash = '0;

   // test operands
   logic [2:0]  t_op;
   logic [1:0]  t_sz, t_rep;
   logic        t_a32, t_dir;
   logic [31:0] t_src, t_dst, t_cnt, t_acc;
   logic [15:0] t_port;
   // expected results
   logic [31:0] e_src, e_dst, e_cnt, e_acc, e_hash;
   logic [3:0]  e_flags = '0;
   logic        e_fault;
   int          e_rd, e_acc_n;

   function automatic logic permit(input logic [15:0] p, input logic [1:0] s);
      return !(p[15:8] == 8'hFF || (p[0] && s != 2'd0));
   endfunction
   assign io_permit = permit(io_port, io_size);

   function automatic logic [31:0] io_val(input int n);
      return 32'h9E37_79B9 * (n + 1);
   endfunction

   // memory responder
   always @(posedge clk) begin
      if (mem_ack || mem_abort) begin
         mem_ack <= 1'b0; mem_abort <= 1'b0;
      end else if (mem_req) begin
         if (flt_en && mem_addr == flt_addr) mem_abort <= 1'b1;
         else begin
            logic [31:0] v;
            v = '0;
            mem_ack <= 1'b1;
            acc_cnt = acc_cnt + 1;
            for (int k = 0; k < (1 << mem_size); k++) begin
               if (mem_we && !mem_probe) mem[12'(mem_addr + k)] = mem_wdata[8*k +: 8];
               v[8*k +: 8] = mem[12'(mem_addr + k)];
            end
            mem_rdata <= v;
         end
      end
   end

   // port responder
   always @(posedge clk) begin
      if (io_ack) io_ack <= 1'b0;
      else if (io_req) begin
         io_ack <= 1'b1;
         if (io_we) io_hash = {io_hash[30:0], io_hash[31]} ^ io_wdata;
         else begin
            io_rdata  <= io_val(io_rd_cnt);
            io_rd_cnt = io_rd_cnt + 1;
         end
      end
   end

   // handshake monitor
   logic        p_wait = 1'b0;
   logic [31:0] p_addr = '0;
   always @(negedge clk) begin
      cycles = cycles + 1;
      if (rst_n) begin
         if (mem_req && io_req) viol = viol + 1;
         if (p_wait && (!mem_req || mem_addr != p_addr)) viol = viol + 1;
      end
      p_wait = mem_req && !mem_ack && !mem_abort;
      p_addr = mem_addr;
      if (cycles > 190000) begin
         failures = failures + 1;
         $display("FAIL watchdog: run hung, act=%0d cycles exp<190000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
      checks = checks + 1;
      if (a !== e) begin
         failures = failures + 1;
         $display("FAIL %s act=%h exp=%h", tag, a, e);
      end
   endtask

   // reference model
   function automatic logic [31:0] ea(input logic [31:0] p);
      return t_a32 ? p : {16'h0, p[15:0]};
   endfunction
   function automatic logic [31:0] stp(input logic [31:0] p, input logic [31:0] d);
      return t_a32 ? p + d : {p[31:16], p[15:0] + d[15:0]};
   endfunction
   function automatic logic [31:0] rrd(input logic [31:0] a, input int n);
      logic [31:0] v = '0;
      for (int k = 0; k < n; k++) v[8*k +: 8] = rmem[12'(a + k)];
      return v;
   endfunction
   function automatic logic isf(input logic [31:0] p);
      return flt_en && ea(p) == flt_addr;
   endfunction
   function automatic logic [3:0] fcalc(input logic [31:0] s, input logic [31:0] d, input int n);
      logic [31:0] df = s - d;
      int mi = 8 * n - 1;
      return {s < d, (n == 4 ? df : (df & ((32'h1 << (8*n)) - 1))) == 0, df[mi],
              (s[mi] ^ d[mi]) & (df[mi] ^ s[mi])};
   endfunction

   task automatic ref_run();
      int n = 1 << t_sz;
      logic [31:0] m = (t_sz == 2) ? 32'hFFFF_FFFF : ((32'h1 << (8*n)) - 1);
      logic [31:0] inc = t_dir ? -32'(n) : 32'(n);
      logic [31:0] s = t_src, d = t_dst, c = t_cnt, a = t_acc, sv, dv;
      logic fin = 1'b0, f;
      e_fault = 1'b0; e_rd = 0; e_acc_n = 0; e_hash = io_hash;
      if ((t_op == 5 || t_op == 6) && !permit(t_port, t_sz)) fin = 1'b1;
      if (t_rep != 0 && (t_a32 ? c : {16'h0, c[15:0]}) == 0) fin = 1'b1;
      for (int it = 0; it < 1000 && !fin; it++) begin
         f = 1'b0; sv = '0; dv = '0;
         case (t_op)
            3'd0: if (isf(s)) f = 1; else begin
                     sv = rrd(ea(s), n); e_acc_n++;
                     if (isf(d)) f = 1; else begin
                        for (int k = 0; k < n; k++) rmem[12'(ea(d) + k)] = sv[8*k +: 8];
                        e_acc_n++;
                     end
                  end
            3'd1: if (isf(s)) f = 1; else begin
                     sv = rrd(ea(s), n); e_acc_n++;
                     if (isf(d)) f = 1; else begin dv = rrd(ea(d), n); e_acc_n++; end
                  end
            3'd2: if (isf(d)) f = 1; else begin
                     for (int k = 0; k < n; k++) rmem[12'(ea(d) + k)] = a[8*k +: 8];
                     e_acc_n++;
                  end
            3'd3: if (isf(s)) f = 1; else begin sv = rrd(ea(s), n); e_acc_n++; end
            3'd4: if (isf(d)) f = 1; else begin dv = rrd(ea(d), n); sv = a & m; e_acc_n++; end
            3'd5: if (isf(d)) f = 1; else begin
                     e_acc_n++;
                     sv = io_val(io_rd_cnt + e_rd) & m; e_rd++;
                     for (int k = 0; k < n; k++) rmem[12'(ea(d) + k)] = sv[8*k +: 8];
                     e_acc_n++;
                  end
            default: if (isf(s)) f = 1; else begin
                     sv = rrd(ea(s), n); e_acc_n++;
                     e_hash = {e_hash[30:0], e_hash[31]} ^ sv;
                  end
         endcase
         if (f) begin e_fault = 1'b1; fin = 1'b1; end
         else begin
            if (t_op inside {0, 1, 3, 6}) s = stp(s, inc);
            if (t_op inside {0, 1, 2, 4, 5}) d = stp(d, inc);
            if (t_rep != 0) c = stp(c, 32'hFFFF_FFFF);
            if (t_op == 3) a = (a & ~m) | sv;
            if (t_op == 1 || t_op == 4) e_flags = fcalc(sv, dv, n);
            if (t_rep == 0 || (t_a32 ? c : {16'h0, c[15:0]}) == 0) fin = 1'b1;
            if ((t_op == 1 || t_op == 4) &&
                ((t_rep == 1 && sv != dv) || (t_rep == 2 && sv == dv))) fin = 1'b1;
         end
      end
      e_src = s; e_dst = d; e_cnt = c; e_acc = a;
   endtask

   task automatic fill_mem(input logic binary);
      for (int i = 0; i < 4096; i++) mem[i] = binary ? 8'($urandom % 2) : 8'($urandom);
   endtask

   task automatic run_one();
      int rd0 = io_rd_cnt, ac0 = acc_cnt, to = 0, bad = 0;
      logic fl;
      for (int i = 0; i < 4096; i++) rmem[i] = mem[i];
      ref_run();
      @(negedge clk);
      op_sel = t_op; elem_size = t_sz; rep_mode = t_rep; wide_addr = t_a32;
      dir_down = t_dir; src_init = t_src; dst_init = t_dst; cnt_init = t_cnt;
      acc_init = t_acc; port_init = t_port; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done && to < 3000) begin @(negedge clk); to++; end
      fl = fault;
      chk("R5 done reached", 32'(done), 32'd1);
      chk("R1/R2 src_ptr", src_ptr, e_src);
      chk("R1/R2 dst_ptr", dst_ptr, e_dst);
      chk("R5/R6 count", count, e_cnt);
      chk("R10 acc", acc, e_acc);
      chk("R7 flags", {28'h0, flag_c, flag_z, flag_s, flag_o}, {28'h0, e_flags});
      chk("R11 fault", 32'(fl), 32'(e_fault));
      chk("R9 port reads", 32'(io_rd_cnt - rd0), 32'(e_rd));
      chk("R8 port write data", io_hash, e_hash);
      chk("R1 memory accesses", 32'(acc_cnt - ac0), 32'(e_acc_n));
      for (int i = 0; i < 4096; i++) if (mem[i] !== rmem[i]) bad++;
      chk("R10 memory image", 32'(bad), 32'd0);
   endtask

   function automatic logic [31:0] rptr(input logic a32);
      return a32 ? 32'h0001_0000 + ($urandom % 4096)
                 : {16'($urandom), 16'($urandom)};
   endfunction

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk("R11 reset done", 32'(done), 32'd0);
      chk("R12 reset idle", {30'h0, mem_req, io_req}, 32'd0);
      chk("R7 reset flags", {28'h0, flag_c, flag_z, flag_s, flag_o}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4: repeated store with zero count, 32-bit
      fill_mem(0);
      t_op = 2; t_sz = 2; t_rep = 1; t_a32 = 1; t_dir = 0; t_src = 32'h10; t_dst = 32'h0001_0100;
      t_cnt = 0; t_acc = 32'h1234_5678; t_port = 0; run_one();
      // R4/R3: 16-bit count zero in low half only
      t_op = 0; t_a32 = 0; t_cnt = 32'h0007_0000; run_one();
      chk("R4 count kept", count, 32'h0007_0000);
      // R8: denied port number for input and output
      t_op = 5; t_rep = 1; t_cnt = 3; t_port = 16'hFF10; run_one();
      t_op = 6; t_sz = 1; t_port = 16'h0031; run_one();
      // R3: 16-bit descending move across zero
      t_op = 0; t_sz = 2; t_rep = 1; t_a32 = 0; t_dir = 1; t_src = 32'hABCD_0001;
      t_dst = 32'h5555_0800; t_cnt = 32'h9999_0003; run_one();
      chk("R3 src upper kept", {16'h0, src_ptr[31:16]}, 32'h0000_ABCD);
      // R10: word load keeps accumulator upper half
      t_op = 3; t_sz = 1; t_rep = 0; t_a32 = 1; t_dir = 0; t_src = 32'h0001_0040;
      t_acc = 32'hDEAD_BEEF; run_one();
      // R6: scan while equal stops at first differing element
      for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
      mem[12'h203] = 8'h5A;
      t_op = 4; t_sz = 0; t_rep = 1; t_dst = 32'h0001_0200; t_cnt = 10; t_acc = 32'hFFFF_FF00;
      run_one();
      chk("R6 scan remaining", count, 32'd6);
      // R6: compare while not equal
      fill_mem(1);
      t_op = 1; t_rep = 2; t_src = 32'h0001_0300; t_dst = 32'h0001_0400; t_cnt = 20; run_one();
      // R11: fault on third destination element of a move
      fill_mem(0);
      t_op = 0; t_sz = 1; t_rep = 1; t_src = 32'h0001_0500; t_dst = 32'h0001_0600; t_cnt = 8;
      flt_en = 1; flt_addr = 32'h0001_0604; run_one();
      chk("R11 count after fault", count, 32'd6);
      // R9: port input probe fault consumes no port data
      t_op = 5; t_sz = 0; t_port = 16'h0060; t_dst = 32'h0001_0700; t_cnt = 4;
      flt_addr = 32'h0001_0701; run_one();
      flt_en = 0;

      // random mix
      for (int r = 0; r < 260; r++) begin
         fill_mem($urandom % 2 == 0);
         t_op  = 3'($urandom % 7);
         t_sz  = 2'($urandom % 3);
         t_rep = 2'($urandom % 3);
         t_a32 = 1'($urandom);
         t_dir = 1'($urandom);
         t_src = rptr(t_a32);
         t_dst = rptr(t_a32);
         t_cnt = t_a32 ? 32'($urandom % 7) : {16'($urandom), 16'($urandom % 7)};
         t_acc = ($urandom % 2) ? 32'($urandom % 2) : $urandom;
         t_port = ($urandom % 8 == 0) ? 16'hFF00 | 16'($urandom % 256) : 16'($urandom);
         flt_en = ($urandom % 5 == 0);
         flt_addr = ea(stp((($urandom % 2) ? t_src : t_dst),
                           (t_dir ? -32'(1 << t_sz) : 32'(1 << t_sz)) * ($urandom % 4)));
         run_one();
      end
      flt_en = 0;
      chk("R12 handshake violations", 32'(viol), 32'd0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule